// File: doc/BRIEF.md
# Multiplexed Timer Register Access Bank

This block is the byte-wide access front end of a free-running timer. The timer has two counters: a 16-bit tick counter and a 24-bit rollover counter that advances each time the tick counter wraps at its period. Each counter owns five wide internal registers: count, capture, period, first compare and second compare. Software never sees these registers directly. It reaches them through one select register and five byte windows, two for the tick counter and three for the rollover counter.

Reading the low tick-count byte takes a snapshot of the whole tick count. When the snapshot-mode input is high, the same read also snapshots the rollover count. The high tick byte and the rollover-count bytes are then served from the snapshot, so a multi-byte read sequence returns one coherent value even while the counters keep moving. Capture triggers, compare outputs and interrupts live elsewhere, so the capture registers here always hold zero.

Access uses a 3-bit `port_sel`: 0 is the select register, 1 and 2 are the tick windows for bits 7:0 and 15:8, and 3, 4 and 5 are the rollover windows for bits 7:0, 15:8 and 23:16. Codes 6 and 7 are unused. Reads are combinational on `rdata`. Writes take effect at the next clock edge.

Top module: `timer_mux_bank`

## Requirements
- R1: After reset, every counter, period, compare, capture and snapshot register and both select fields are zero.
- R2: A write to port 0 stores bits 2:0 as the tick select and bits 6:4 as the rollover select. A read of port 0 returns {0, rollover select, 0, tick select}, with bits 7 and 3 always zero.
- R3: The select codes are 000 count, 001 capture, 010 period, 011 compare 1 and 100 compare 2. Tick ports 1 and 2 reach bits 7:0 and 15:8 of the register the tick select picks. Rollover ports 3, 4 and 5 reach bits 7:0, 15:8 and 23:16 of the register the rollover select picks. Period and compare registers can be both written and read back byte by byte.
- R4: Capture registers (code 001) read as zero, and writes to them are ignored.
- R5: Select codes 101 to 111, and ports 6 and 7, read as zero. Writes to them change no register.
- R6: On each clock with `tick` high, the tick count increments. If the tick count equals the tick period, it goes to zero instead, and the rollover count steps. A rollover step sets the rollover count to zero if it equals the rollover period, and otherwise increments it. A tick count above the period rolls over from 0xFFFF to 0 with no rollover step. With `tick` low, neither count changes.
- R7: A read of port 1 while the tick select is 000 returns the live low count byte and snapshots the full tick count. Port 2 with tick select 000 returns bits 15:8 of that snapshot.
- R8: If `latch_mode` is 1 during that latching read, the rollover count is snapshotted too. Rollover ports with select 000 always return the rollover snapshot. A latching read with `latch_mode` 0 leaves the rollover snapshot unchanged.
- R9: A byte write to a count register loads that byte at the next clock edge and overrides that cycle's increment. A tick-count write also suppresses that cycle's rollover step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for this cycle |
| latch_mode | input | 1 | 1: a latching read also snapshots the rollover count |
| port_sel | input | 3 | Byte window: 0 select, 1-2 tick bytes, 3-5 rollover bytes |
| wr_en | input | 1 | Write strobe for the selected window |
| rd_en | input | 1 | Read strobe (only side effect: snapshot) |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the selected window, combinational |

## Verification
A corrupted select field sends every later byte access to the wrong register. The next read of a tick or rollover window shows this on the same cycle, as a period or compare value where a count was expected, or the reverse. A count that steps wrongly, or wraps at the wrong value, appears on the very next live low-byte read. A faulty rollover step becomes visible only after the next snapshot read with `latch_mode` high. A snapshot taken one cycle late shows up as a high tick byte that disagrees with the low byte returned on the latching read. The bench reads back through the ports every cycle and compares them against a behavioural model of the counters, snapshots and register file.

// File: rtl/timer_mux_bank.sv
module timer_mux_bank (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       latch_mode,
  input  logic [2:0] port_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  logic [2:0]  tsel, osel;
  logic [15:0] cnt, tper, tcmp1, tcmp2, tsnap;
  logic [23:0] ovf, oper, ocmp1, ocmp2, osnap;
  logic [15:0] tview;
  logic [23:0] oview, oshift;
  logic [1:0]  olane;

  wire t_port   = (port_sel == 3'd1) || (port_sel == 3'd2);
  wire o_port   = (port_sel == 3'd3) || (port_sel == 3'd4) || (port_sel == 3'd5);
  wire tlane    = (port_sel == 3'd2);
  assign olane  = 2'(port_sel - 3'd3);
  wire twr      = wr_en && t_port;
  wire owr      = wr_en && o_port;
  wire twr_cnt  = twr && (tsel == 3'd0);
  wire owr_cnt  = owr && (osel == 3'd0);
  wire do_latch = rd_en && (port_sel == 3'd1) && (tsel == 3'd0);
  wire wrap_t   = tick && !twr_cnt && (cnt == tper);

  function automatic logic [15:0] put16(input logic [15:0] v, input logic lane, input logic [7:0] b);
    return (v & ~(16'h00FF << {lane, 3'b000})) | ({8'h00, b} << {lane, 3'b000});
  endfunction

  function automatic logic [23:0] put24(input logic [23:0] v, input logic [1:0] lane, input logic [7:0] b);
    return (v & ~(24'h0000FF << {lane, 3'b000})) | ({16'h0000, b} << {lane, 3'b000});
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsel <= '0;  osel <= '0;
      cnt <= '0;   tper <= '0;  tcmp1 <= '0; tcmp2 <= '0; tsnap <= '0;
      ovf <= '0;   oper <= '0;  ocmp1 <= '0; ocmp2 <= '0; osnap <= '0;
    end else begin
      if (wr_en && port_sel == 3'd0) begin
        tsel <= wdata[2:0];
        osel <= wdata[6:4];
      end
      if (twr) begin
        case (tsel)
          3'd2: tper  <= put16(tper, tlane, wdata);
          3'd3: tcmp1 <= put16(tcmp1, tlane, wdata);
          3'd4: tcmp2 <= put16(tcmp2, tlane, wdata);
          default: ;
        endcase
      end
      if (owr) begin
        case (osel)
          3'd2: oper  <= put24(oper, olane, wdata);
          3'd3: ocmp1 <= put24(ocmp1, olane, wdata);
          3'd4: ocmp2 <= put24(ocmp2, olane, wdata);
          default: ;
        endcase
      end
      if (twr_cnt)     cnt <= put16(cnt, tlane, wdata);
      else if (wrap_t) cnt <= '0;
      else if (tick)   cnt <= cnt + 16'd1;
      if (owr_cnt)     ovf <= put24(ovf, olane, wdata);
      else if (wrap_t) ovf <= (ovf == oper) ? 24'd0 : ovf + 24'd1;
      if (do_latch) begin
        tsnap <= cnt;
        if (latch_mode) osnap <= ovf;
      end
    end
  end

  always_comb begin
    case (tsel)
      3'd0:    tview = {tsnap[15:8], cnt[7:0]};
      3'd2:    tview = tper;
      3'd3:    tview = tcmp1;
      3'd4:    tview = tcmp2;
      default: tview = '0;
    endcase
    case (osel)
      3'd0:    oview = osnap;
      3'd2:    oview = oper;
      3'd3:    oview = ocmp1;
      3'd4:    oview = ocmp2;
      default: oview = '0;
    endcase
  end

  assign oshift = oview >> {olane, 3'b000};

  always_comb begin
    if (port_sel == 3'd0) rdata = {1'b0, osel, 1'b0, tsel};
    else if (t_port)      rdata = tlane ? tview[15:8] : tview[7:0];
    else if (o_port)      rdata = oshift[7:0];
    else                  rdata = '0;
  end

  assert_sel_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_sel == 3'd0) |-> (rdata[7] == 1'b0 && rdata[3] == 1'b0));
  assert_rsvd_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (t_port && tsel > 3'd4) |-> (rdata == 8'h00));
  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !twr_cnt && cnt != tper) |=> (cnt == $past(cnt) + 16'd1));
  assert_cnt_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_t |=> (cnt == 16'd0));
  assert_ovf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_t && !owr_cnt) |=> $stable(ovf));
  assert_cnt_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !twr_cnt) |=> $stable(cnt));
  assert_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_latch |=> (tsnap == $past(cnt)));
  assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_latch && latch_mode) |=> $stable(osnap));
  assert_cnt_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (twr_cnt && port_sel == 3'd1) |=> (cnt[7:0] == $past(wdata)));
endmodule

// File: tb/timer_mux_bank_tb.sv
module timer_mux_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, latch_mode = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] port_sel = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [2:0]  m_ts, m_os;
  logic [15:0] m_cnt, m_tsnap;
  logic [23:0] m_ovf, m_osnap;
  logic [23:0] m_treg [5];
  logic [23:0] m_oreg [5];

  always #10 clk = ~clk;

  timer_mux_bank dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .latch_mode(latch_mode),
    .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata));

  function automatic logic [7:0] byte_of(input logic [23:0] v, input int lane);
    return 8'((v >> (8 * lane)) & 24'hFF);
  endfunction

  function automatic logic [7:0] exp_rd(input int p);
    if (p == 0) return {1'b0, m_os, 1'b0, m_ts};
    if (p == 1 || p == 2) begin
      if (m_ts == 0) return (p == 1) ? m_cnt[7:0] : m_tsnap[15:8];
      if (m_ts >= 2 && m_ts <= 4) return byte_of(m_treg[m_ts], p - 1);
      return 8'h00;
    end
    if (p >= 3 && p <= 5) begin
      if (m_os == 0) return byte_of(m_osnap, p - 3);
      if (m_os >= 2 && m_os <= 4) return byte_of(m_oreg[m_os], p - 3);
      return 8'h00;
    end
    return 8'h00;
  endfunction

  function automatic string tag_for(input int p);
    if (p == 0) return "R2";
    if (p >= 6) return "R5";
    if (p <= 2) begin
      if (m_ts == 0) return (p == 1) ? "R6" : "R7";
      if (m_ts == 1) return "R4";
      return (m_ts <= 4) ? "R3" : "R5";
    end
    if (m_os == 0) return "R8";
    if (m_os == 1) return "R4";
    return (m_os <= 4) ? "R3" : "R5";
  endfunction

  task automatic model_reset();
    m_ts = 0; m_os = 0; m_cnt = 0; m_tsnap = 0; m_ovf = 0; m_osnap = 0;
    for (int i = 0; i < 5; i++) begin m_treg[i] = 0; m_oreg[i] = 0; end
  endtask

  task automatic model_step(input int p, input bit w, input bit r, input logic [7:0] d,
                            input bit tk, input bit lm);
    logic [15:0] c0;
    logic [23:0] o0, mask;
    bit twc, owc, wrap;
    c0 = m_cnt; o0 = m_ovf;
    twc = w && (p == 1 || p == 2) && m_ts == 0;
    owc = w && (p >= 3 && p <= 5) && m_os == 0;
    wrap = tk && !twc && (c0 == m_treg[2][15:0]);
    if (r && p == 1 && m_ts == 0) begin
      m_tsnap = c0;
      if (lm) m_osnap = o0;
    end
    if (twc) begin
      mask = 24'hFF << (8 * (p - 1));
      m_cnt = 16'((c0 & ~mask[15:0]) | (16'(d) << (8 * (p - 1))));
    end else if (wrap) m_cnt = 0;
    else if (tk) m_cnt = c0 + 16'd1;
    if (owc) begin
      mask = 24'hFF << (8 * (p - 3));
      m_ovf = (o0 & ~mask) | (24'(d) << (8 * (p - 3)));
    end else if (wrap) m_ovf = (o0 == m_oreg[2]) ? 24'd0 : o0 + 24'd1;
    if (w && (p == 1 || p == 2) && m_ts >= 2 && m_ts <= 4) begin
      mask = 24'hFF << (8 * (p - 1));
      m_treg[m_ts] = ((m_treg[m_ts] & ~mask) | (24'(d) << (8 * (p - 1)))) & 24'hFFFF;
    end
    if (w && p >= 3 && p <= 5 && m_os >= 2 && m_os <= 4) begin
      mask = 24'hFF << (8 * (p - 3));
      m_oreg[m_os] = (m_oreg[m_os] & ~mask) | (24'(d) << (8 * (p - 3)));
    end
    if (w && p == 0) begin m_ts = d[2:0]; m_os = d[6:4]; end
  endtask

  task automatic step(input int p, input bit w, input bit r, input logic [7:0] d,
                      input bit tk, input bit lm, input string tag);
    logic [7:0] e;
    string t;
    @(negedge clk);
    port_sel = 3'(p); wr_en = w; rd_en = r; wdata = d; tick = tk; latch_mode = lm;
    #5;
    e = exp_rd(p);
    t = (tag == "") ? tag_for(p) : tag;
    checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s port %0d actual %h expected %h", t, p, rdata, e);
    end
    model_step(p, w, r, d, tk, lm);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state through every window
    for (int p = 0; p < 8; p++) step(p, 0, 0, 8'h00, 0, 0, "R1");
    step(1, 0, 1, 8'h00, 0, 1, "R1");
    step(2, 0, 0, 8'h00, 0, 0, "R1");
    // R2: reserved select bits read zero
    step(0, 1, 0, 8'hFF, 0, 0, "R2");
    step(0, 0, 0, 8'h00, 0, 0, "R2");
    // R5: reserved code reads zero, write ignored
    step(1, 1, 0, 8'h55, 0, 0, "R5");
    step(1, 0, 0, 8'h00, 0, 0, "R5");
    step(6, 1, 0, 8'hAA, 0, 0, "R5");
    // R3: periods through byte windows
    step(0, 1, 0, 8'h22, 0, 0, "R3");
    step(1, 1, 0, 8'h05, 0, 0, "R3");
    step(2, 1, 0, 8'h00, 0, 0, "R3");
    step(3, 1, 0, 8'h02, 0, 0, "R3");
    step(1, 0, 0, 8'h00, 0, 0, "R3");
    step(3, 0, 0, 8'h00, 0, 0, "R3");
    // R4: capture reads zero, writes ignored
    step(0, 1, 0, 8'h11, 0, 0, "R4");
    step(2, 1, 0, 8'h77, 0, 0, "R4");
    step(2, 0, 0, 8'h00, 0, 0, "R4");
    step(4, 1, 0, 8'h77, 0, 0, "R4");
    step(4, 0, 0, 8'h00, 0, 0, "R4");
    // R6 and R8: count, wrap, snapshot with rollover
    step(0, 1, 0, 8'h00, 0, 0, "R6");
    for (int i = 0; i < 24; i++) begin
      step(1, 0, 1, 8'h00, 1, i[0], "R6");
      step(3, 0, 0, 8'h00, 0, 0, "R8");
    end
    // R9: count write overrides increment
    step(1, 1, 0, 8'h03, 1, 0, "R9");
    step(1, 0, 1, 8'h00, 0, 0, "R9");
    step(2, 1, 0, 8'h12, 1, 0, "R9");
    step(1, 0, 1, 8'h00, 0, 0, "R9");
    step(2, 0, 0, 8'h00, 0, 0, "R7");
    step(3, 1, 0, 8'h09, 1, 0, "R9");
    step(1, 0, 1, 8'h00, 0, 1, "R9");
    step(3, 0, 0, 8'h00, 0, 0, "R8");
    step(1, 1, 0, 8'h00, 0, 0, "R9");
    step(2, 1, 0, 8'h00, 0, 0, "R9");
    // random mix
    for (int i = 0; i < 6000; i++) begin
      int p;
      logic [7:0] d;
      p = $urandom_range(0, 7);
      d = ($urandom % 3 != 0) ? 8'($urandom_range(0, 12)) : 8'($urandom);
      if (p == 0) d = d & 8'h33;
      step(p, ($urandom % 5) == 0, $urandom % 2, d, $urandom % 4 != 0, $urandom % 2, "");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule